// File: doc/BRIEF.md
# Asynchronous pseudo-static memory command front-end

This block is the command decoder and data path of a 16-bit pseudo-static memory when it runs in its plain asynchronous mode. The host drives active-low chip select, address-valid, write enable, output enable and two byte enables, plus an active-high register-select input. The block turns these strobes into word reads, byte-masked writes and configuration register loads. It also handles no-ops, deselect and a deep power-down state that blocks all array traffic. The storage is a small array whose depth is a parameter, and the array uses only the low address bits.

All strobes, the address and the input data pass through a two-flop synchroniser clocked by a free-running internal clock. A further register holds the previous synchronised sample, and edges are found by comparing the two. Every state change is therefore synchronous. The data bus is split into input data, output data and a per-byte output enable. The bidirectional pin is formed outside this block.

The controller has six states: IDLE, READ, WRITE, HOLD, CREG and DPD. Its transitions are:
- start-read: IDLE to READ
- start-write: IDLE to WRITE
- start-load: IDLE to CREG, and DPD to CREG
- read-to-write: READ to WRITE
- read-end: READ to IDLE
- commit: WRITE to HOLD
- release: HOLD to IDLE
- load-done: CREG to IDLE
- load-sleep: CREG to DPD

Top module: `psram_async_front`

## Requirements
- R1: After reset, `bus_cfg` is 0x8000 (bit 15 set means asynchronous mode), `refresh_cfg` is 0x0010 (bit 4 set means deep power-down disabled), and `dq_oe` is 0.
- R2: With `cs_n`, `adv_n` and `oe_n` low and `we_n` high, the block drives the stored word. `dq_oe[1]` and `dq_o[15:8]` follow `ub_n` low, and `dq_oe[0]` and `dq_o[7:0]` follow `lb_n` low. A byte that is not enabled reads as zero with its enable low.
- R3: A write stores only the bytes whose enables were low. The other byte of the word keeps its old value.
- R4: While `we_n` is low, `oe_n` has no effect: the cycle is a write and `dq_oe` stays 0.
- R5: A write commits on the first rising edge among `cs_n`, `we_n` and any byte enable that was low. The data, address and byte mask are taken from just before that edge. Later data changes in the same cycle are not stored.
- R6: A write started with `cre` high loads a configuration register instead of the array. `addr[19]`=1 selects `bus_cfg` and `addr[19]`=0 selects `refresh_cfg`. The value comes from `addr[15:0]`, and the array is untouched.
- R7: `cre` is sampled only when an access starts from idle. Raising it during a write in progress has no effect, and the write completes normally.
- R8: Loading `refresh_cfg` with bit 4 clear enters deep power-down. In that state reads leave `dq_oe` at 0 and writes are ignored.
- R9: Deep power-down is left only by a `refresh_cfg` load with bit 4 set. A `bus_cfg` load during deep power-down updates `bus_cfg` and keeps the block asleep.
- R10: With `cs_n` high, or with `cs_n` low but both `oe_n` and `we_n` high, nothing is driven and the array is unchanged.
- R11: An access starts only while `adv_n` is low. With `adv_n` high, read or write strobes neither drive the bus nor change the array.
- R12: The array index is the address modulo the depth, so addresses that differ only above the low index bits refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running sampling clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cs_n | input | 1 | chip select, active low |
| adv_n | input | 1 | address valid, active low |
| we_n | input | 1 | write enable, active low |
| oe_n | input | 1 | output enable, active low |
| ub_n | input | 1 | upper byte enable (bits 15:8), active low |
| lb_n | input | 1 | lower byte enable (bits 7:0), active low |
| cre | input | 1 | configuration register select |
| addr | input | 21 | word address, or register value during a load |
| dq_i | input | 16 | write data from the pad |
| dq_o | output | 16 | read data to the pad |
| dq_oe | output | 2 | per-byte pad drive enable (bit 1 upper, bit 0 lower) |
| bus_cfg | output | 16 | bus configuration register |
| refresh_cfg | output | 16 | refresh configuration register |

## Verification
The bench builds the block with DEPTH=16 and SYNC_STAGES=2. The short depth lets the bench fill every word of the array and keep a full mirror of it. It also brings address aliasing within reach of the 21-bit address: two addresses far apart in the upper bits must land on the same word. The two-stage synchroniser keeps the edge-to-commit delay short, so every strobe ordering (lower byte first, write enable last, select raised mid-write) fits in a few cycles of settling.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int ADDR_W  = 21;
    localparam int DATA_W  = 16;
    localparam int BYTES   = DATA_W / 8;
    localparam int CFG_W   = 16;

    // address bit choosing the target register during a load
    localparam int SEL_BIT = 19;
    // refresh register bit that keeps deep power-down disabled when set
    localparam int DPD_BIT = 4;

    localparam logic [CFG_W-1:0] BUS_CFG_RST     = 16'h8000;
    localparam logic [CFG_W-1:0] REFRESH_CFG_RST = 16'h0010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_HOLD,
        ST_CREG,
        ST_DPD
    } state_t;

    typedef struct packed {
        logic              cs_n;
        logic              adv_n;
        logic              we_n;
        logic              oe_n;
        logic [BYTES-1:0]  be_n;
        logic              cre;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] din;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    localparam pins_t PINS_IDLE = '{
        cs_n:  1'b1,
        adv_n: 1'b1,
        we_n:  1'b1,
        oe_n:  1'b1,
        be_n:  {BYTES{1'b1}},
        cre:   1'b0,
        addr:  '0,
        din:   '0
    };

endpackage

// File: rtl/psram_sync.sv
module psram_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/psram_array.sv
module psram_array
    import psram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BYTES-1:0]  mask,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    // DEPTH is expected to be a power of two
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < BYTES; b++) begin
                if (mask[b]) begin
                    mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/psram_cfg.sv
module psram_cfg
    import psram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sel_bus,
    input  logic [CFG_W-1:0] value,
    output logic [CFG_W-1:0] bus_cfg,
    output logic [CFG_W-1:0] refresh_cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_cfg     <= BUS_CFG_RST;
            refresh_cfg <= REFRESH_CFG_RST;
        end else if (load) begin
            if (sel_bus) begin
                bus_cfg <= value;
            end else begin
                refresh_cfg <= value;
            end
        end
    end

endmodule

// File: rtl/psram_fsm.sv
module psram_fsm
    import psram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  pins_t            cur,
    input  pins_t            prv,
    input  logic             dpd_off,
    output state_t           state_o,
    output logic             rd_en,
    output logic             mem_we,
    output logic [BYTES-1:0] mem_mask,
    output logic             cfg_load,
    output logic             cfg_sel_bus
);

    state_t state, state_nx;

    logic             cs_rise;
    logic             we_rise;
    logic [BYTES-1:0] be_rise;
    logic             write_edge;
    logic             load_edge;
    logic             start;
    logic             stay_awake;
    logic             unused_fsm;

    assign unused_fsm = ^{cur, prv};

    assign cs_rise    = cur.cs_n & ~prv.cs_n;
    assign we_rise    = cur.we_n & ~prv.we_n;
    assign be_rise    = cur.be_n & ~prv.be_n;
    assign write_edge = cs_rise | we_rise | (|be_rise);
    assign load_edge  = cs_rise | we_rise;
    assign start      = ~cur.cs_n & ~cur.adv_n;

    // deep power-down flag after the load that is committing now
    assign stay_awake = prv.addr[SEL_BIT] ? dpd_off : prv.addr[DPD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start && !cur.we_n && cur.cre) begin
                    state_nx = ST_CREG;
                end else if (start && !cur.we_n) begin
                    state_nx = ST_WRITE;
                end else if (start && !cur.oe_n) begin
                    state_nx = ST_READ;
                end
            end
            ST_READ: begin
                if (cur.cs_n || (cur.oe_n && cur.we_n)) begin
                    state_nx = ST_IDLE;
                end else if (!cur.we_n) begin
                    state_nx = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (write_edge) begin
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (cur.cs_n || cur.we_n) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_CREG: begin
                if (load_edge) begin
                    state_nx = stay_awake ? ST_IDLE : ST_DPD;
                end
            end
            ST_DPD: begin
                if (start && !cur.we_n && cur.cre) begin
                    state_nx = ST_CREG;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_en       = (state == ST_READ) && !cur.cs_n && !cur.oe_n && cur.we_n;
        mem_we      = (state == ST_WRITE) && write_edge;
        mem_mask    = ~prv.be_n;
        cfg_load    = (state == ST_CREG) && load_edge;
        cfg_sel_bus = prv.addr[SEL_BIT];
    end

    assign state_o = state;

endmodule

// File: rtl/psram_async_front.sv
module psram_async_front
    import psram_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              cre,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic [BYTES-1:0]  dq_oe,
    output logic [CFG_W-1:0]  bus_cfg,
    output logic [CFG_W-1:0]  refresh_cfg
);

    localparam int MEM_AW = $clog2(DEPTH);

    pins_t             raw_pins;
    pins_t             cur;
    pins_t             prv;
    logic [PINS_W-1:0] cur_bits;

    state_t            fsm_state;
    logic              rd_en;
    logic              mem_we;
    logic [BYTES-1:0]  mem_mask;
    logic              cfg_load;
    logic              cfg_sel_bus;
    logic [DATA_W-1:0] rdata;

    always_comb begin
        raw_pins.cs_n  = cs_n;
        raw_pins.adv_n = adv_n;
        raw_pins.we_n  = we_n;
        raw_pins.oe_n  = oe_n;
        raw_pins.be_n  = {ub_n, lb_n};
        raw_pins.cre   = cre;
        raw_pins.addr  = addr;
        raw_pins.din   = dq_i;
    end

    psram_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_pins),
        .q     (cur_bits)
    );

    assign cur = pins_t'(cur_bits);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv <= PINS_IDLE;
        end else begin
            prv <= cur;
        end
    end

    psram_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur         (cur),
        .prv         (prv),
        .dpd_off     (refresh_cfg[DPD_BIT]),
        .state_o     (fsm_state),
        .rd_en       (rd_en),
        .mem_we      (mem_we),
        .mem_mask    (mem_mask),
        .cfg_load    (cfg_load),
        .cfg_sel_bus (cfg_sel_bus)
    );

    psram_array #(
        .DEPTH (DEPTH),
        .AW    (MEM_AW)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .mask  (mem_mask),
        .waddr (prv.addr[MEM_AW-1:0]),
        .wdata (prv.din),
        .raddr (cur.addr[MEM_AW-1:0]),
        .rdata (rdata)
    );

    psram_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cfg_load),
        .sel_bus     (cfg_sel_bus),
        .value       (prv.addr[CFG_W-1:0]),
        .bus_cfg     (bus_cfg),
        .refresh_cfg (refresh_cfg)
    );

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dq_oe[b]       = rd_en && !cur.be_n[b];
        assign dq_o[b*8 +: 8] = (rd_en && !cur.be_n[b]) ? rdata[b*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/psram_async_front_chk.sv
module psram_async_front_chk
    import psram_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [BYTES-1:0] dq_oe,
    input state_t           state,
    input logic             cfg_load,
    input logic [CFG_W-1:0] bcr,
    input logic [CFG_W-1:0] rcr
);

    AST_DPD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DPD) |-> (dq_oe == '0)); // R8

    AST_NONREAD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READ) |-> (dq_oe == '0)); // R10

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(bcr) && $stable(rcr))); // R6

    AST_LOAD_ONLY_FROM_CREG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (state == ST_CREG)); // R7

    AST_DPD_EXIT_VIA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DPD && state != ST_DPD) |-> (state == ST_CREG)); // R9

endmodule

bind psram_async_front psram_async_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dq_oe    (dq_oe),
    .state    (fsm_state),
    .cfg_load (cfg_load),
    .bcr      (bus_cfg),
    .rcr      (refresh_cfg)
);

// File: tb/psram_async_front_tb_top.sv
module psram_async_front_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, adv_n, we_n, oe_n, ub_n, lb_n, cre;
    logic [20:0] addr;
    logic [15:0] dq_i;
    logic [15:0] dq_o;
    logic [1:0]  dq_oe;
    logic [15:0] bus_cfg, refresh_cfg;

    int checks = 0;
    int errors = 0;
    bit settled = 1'b0;
    bit done = 1'b0;

    logic [15:0] m_mem [DEPTH];
    logic [15:0] m_bcr;
    logic [15:0] m_rcr;
    bit          m_dpd;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_async_front #(.DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
        .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .cre(cre), .addr(addr),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .bus_cfg(bus_cfg),
        .refresh_cfg(refresh_cfg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int idx(input logic [20:0] a);
        return int'(a) % DEPTH;
    endfunction

    task automatic model_store(input logic [20:0] a, input logic [15:0] d, input logic u, input logic l);
        if (!u) m_mem[idx(a)][15:8] = d[15:8];
        if (!l) m_mem[idx(a)][7:0]  = d[7:0];
    endtask

    task automatic setp(input logic c, input logic a, input logic w, input logic o,
                        input logic u, input logic l, input logic r,
                        input logic [20:0] ad, input logic [15:0] d);
        settled = 1'b0;
        cs_n = c; adv_n = a; we_n = w; oe_n = o; ub_n = u; lb_n = l; cre = r;
        addr = ad; dq_i = d;
    endtask

    task automatic settle;
        repeat (6) @(negedge clk);
        settled = 1'b1;
    endtask

    task automatic idle_pins;
        setp(1, 1, 1, 1, 1, 1, 0, '0, '0);
        settle;
    endtask

    task automatic do_write(input logic [20:0] ad, input logic [15:0] d,
                            input logic u, input logic l, input logic a);
        setp(0, a, 0, 1, u, l, 0, ad, d);
        settle;
        settled = 1'b0;
        we_n = 1'b1;
        if (!a && !m_dpd) model_store(ad, d, u, l);
        settle;
        idle_pins;
    endtask

    task automatic do_read(input logic [20:0] ad, input logic u, input logic l, input string req);
        logic [1:0]  eo;
        logic [15:0] ed;
        setp(0, 0, 1, 0, u, l, 0, ad, '0);
        settle;
        eo = m_dpd ? 2'b00 : ~{u, l};
        ed = {eo[1] ? m_mem[idx(ad)][15:8] : 8'h00, eo[0] ? m_mem[idx(ad)][7:0] : 8'h00};
        chk(req, 32'(dq_oe), 32'(eo));
        chk(req, 32'(dq_o), 32'(ed));
        idle_pins;
    endtask

    task automatic cr_load(input logic sel, input logic [15:0] val, input string req);
        setp(0, 0, 0, 1, 1, 1, 1, {1'b0, sel, 3'b000, val}, '0);
        settle;
        settled = 1'b0;
        we_n = 1'b1;
        if (sel) m_bcr = val;
        else begin
            m_rcr = val;
            m_dpd = !val[4];
        end
        settle;
        idle_pins;
        chk(req, 32'(bus_cfg), 32'(m_bcr));
        chk(req, 32'(refresh_cfg), 32'(m_rcr));
    endtask

    // per-clock comparison against the reference model once the pins are stable
    always @(negedge clk) begin
        if (settled && rst_n && !done) begin
            logic [1:0]  eo;
            logic [15:0] ed;
            eo = (!cs_n && !adv_n && !oe_n && we_n && !m_dpd) ? ~{ub_n, lb_n} : 2'b00;
            ed = {eo[1] ? m_mem[idx(addr)][15:8] : 8'h00, eo[0] ? m_mem[idx(addr)][7:0] : 8'h00};
            chk(eo != 2'b00 ? "R2" : (m_dpd ? "R8" : "R10"), 32'(dq_oe), 32'(eo));
            chk(eo != 2'b00 ? "R2" : (m_dpd ? "R8" : "R10"), 32'(dq_o), 32'(ed));
            chk("R6", {bus_cfg, refresh_cfg}, {m_bcr, m_rcr});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_bcr = 16'h8000;
        m_rcr = 16'h0010;
        m_dpd = 1'b0;
        rst_n = 1'b0;
        setp(1, 1, 1, 1, 1, 1, 0, '0, '0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", 32'(bus_cfg), 32'h8000);
        chk("R1", 32'(refresh_cfg), 32'h0010);
        chk("R1", 32'(dq_oe), 32'h0);
        settle;

        // fill every word (R3 full-word writes)
        for (int i = 0; i < DEPTH; i++) begin
            do_write(21'(i), 16'(i * 16'h1111) ^ 16'h0F0F, 0, 0, 0);
        end
        do_read(21'd1, 0, 0, "R2");
        do_read(21'd6, 1, 0, "R2");
        do_read(21'd6, 0, 1, "R2");

        // R3 upper byte only
        do_write(21'd2, 16'hABCD, 0, 1, 0);
        do_read(21'd2, 0, 0, "R3");
        do_write(21'd4, 16'h1234, 1, 0, 0);
        do_read(21'd4, 0, 0, "R3");

        // R4 output enable ignored during a write
        setp(0, 0, 0, 0, 0, 0, 0, 21'd9, 16'h4B4B);
        settle;
        chk("R4", 32'(dq_oe), 32'h0);
        settled = 1'b0;
        we_n = 1'b1;
        model_store(21'd9, 16'h4B4B, 0, 0);
        settle;
        chk("R4", 32'(dq_o), 32'h4B4B);
        idle_pins;

        // R5 lower byte enable rises first, later data ignored
        setp(0, 0, 0, 1, 0, 0, 0, 21'd7, 16'hA1A2);
        settle;
        settled = 1'b0;
        lb_n = 1'b1;
        model_store(21'd7, 16'hA1A2, 0, 0);
        settle;
        settled = 1'b0;
        dq_i = 16'hB3B4;
        settle;
        settled = 1'b0;
        we_n = 1'b1;
        settle;
        idle_pins;
        do_read(21'd7, 0, 0, "R5");

        // R10 no-op with select low leaves array alone
        setp(0, 0, 1, 1, 0, 0, 0, 21'd0, 16'hFFFF);
        settle;
        chk("R10", 32'(dq_oe), 32'h0);
        idle_pins;
        do_read(21'd0, 0, 0, "R10");

        // R11 address-valid high blocks access
        setp(0, 1, 1, 0, 0, 0, 0, 21'd2, '0);
        settle;
        chk("R11", 32'(dq_oe), 32'h0);
        idle_pins;
        do_write(21'd3, 16'hDEAD, 0, 0, 1);
        do_read(21'd3, 0, 0, "R11");

        // R12 aliasing on the low index bits
        do_write(21'h1F0A3, 16'h7788, 0, 0, 0);
        do_read(21'h00003, 0, 0, "R12");

        // R6 register loads
        cr_load(1'b1, 16'h1234, "R6");
        cr_load(1'b0, 16'h0055, "R6");
        do_read(21'd5, 0, 0, "R6");

        // R7 select raised mid-write is ignored
        setp(0, 0, 0, 1, 0, 0, 0, 21'h01235, 16'hC0DE);
        settle;
        settled = 1'b0;
        cre = 1'b1;
        settle;
        settled = 1'b0;
        we_n = 1'b1;
        model_store(21'h01235, 16'hC0DE, 0, 0);
        settle;
        idle_pins;
        chk("R7", 32'(refresh_cfg), 32'(m_rcr));
        chk("R7", 32'(bus_cfg), 32'(m_bcr));
        do_read(21'd5, 0, 0, "R7");

        // R8 deep power-down entry, reads and writes ignored
        cr_load(1'b0, 16'h0000, "R8");
        do_read(21'd1, 0, 0, "R8");
        do_write(21'd1, 16'h5A5A, 0, 0, 0);

        // R9 bus register load keeps sleeping, refresh load with bit 4 wakes
        cr_load(1'b1, 16'h00F0, "R9");
        do_read(21'd1, 0, 0, "R9");
        cr_load(1'b0, 16'h0010, "R9");
        do_read(21'd1, 0, 0, "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule